// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block carries out one vector gather operation. A caller presents a 64-bit base address, a vector of signed indices, a scale code, a per-lane mask and the old contents of the destination, and pulses `start`. The sequencer captures all of these. It then walks the enabled lanes from the lowest to the highest. For each one it forms an element address and issues a single read on a simple memory port that uses request, grant and valid signals. The returned element is merged into the destination copy.

Index width (32 or 64 bits), element width (32 or 64 bits) and vector length (128 or 256 bits) are chosen per operation, and together they fix how many lanes take part. The mask is laid out in lanes as wide as the data elements, not the index elements. A lane takes part when the top bit of its mask lane is set. Each mask lane is cleared once its element has been merged, so the state left behind by a partly finished gather shows which lanes are still owed. When the operation ends, the whole mask reads back as zero and `done` pulses for one cycle.

Top module: `gather_seq`

## Requirements
- R1: Lane k is enabled only when the most significant bit of its mask lane is 1. The mask lane is 32 bits wide (bit 32k+31) when `dataWide`=0 and 64 bits wide (bit 64k+63) when `dataWide`=1. No other mask bit affects whether a lane is enabled.
- R2: The number of lanes depends on all three mode inputs. With `vecLong`=0 there are 4 lanes when both `idxWide` and `dataWide` are 0, and 2 lanes otherwise. With `vecLong`=1 there are 8 lanes when both are 0, and 4 lanes otherwise. Lanes at or above this count are never requested.
- R3: The address of lane k is `baseAddr` + (sign-extended index k shifted left by `scaleSel`), taken modulo 2^64. Index k is `idxVec[64k+63:64k]` when `idxWide`=1 and `idxVec[32k+31:32k]` when `idxWide`=0. The scale code 0..3 selects a factor of 1, 2, 4 or 8.
- R4: An active lane whose mask bit is clear keeps its value from `destIn` in `destOut`.
- R5: An enabled lane receives `memRdata[63:0]` when `dataWide`=1, or `memRdata[31:0]` when `dataWide`=0. During every request, `memWide` equals the captured `dataWide`.
- R6: Enabled lanes are requested in ascending lane order, with at most one read outstanding. Once `memReq` is raised, it and `memAddr` hold steady until the cycle in which `memGnt` is seen.
- R7: Each lane's whole mask lane is cleared when its data is merged. When `done` is high, `maskOut` is entirely zero.
- R8: All bits of `destOut` at or above lane count × element width are zero after a gather.
- R9: `done` is high for exactly one cycle: the cycle after the clock edge on which the last enabled lane's `memValid` is taken. If no lane is enabled, no request is made and `done` is high in the second cycle after the `start` edge.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running gather completes with the inputs it captured, and no second gather follows it.
- R11: After reset, `destOut` and `maskOut` are zero, and `busy`, `memReq` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gather; sampled only when idle |
| baseAddr | input | 64 | Base byte address |
| idxVec | input | VEC_W | Packed signed indices |
| scaleSel | input | 2 | Index shift amount (factor 1/2/4/8) |
| maskIn | input | VEC_W | Lane mask, sign bit of each data-wide lane enables it |
| destIn | input | VEC_W | Previous destination contents |
| idxWide | input | 1 | 1: 64-bit indices, 0: 32-bit |
| dataWide | input | 1 | 1: 64-bit elements, 0: 32-bit |
| vecLong | input | 1 | 1: 256-bit vector length, 0: 128-bit |
| memReq | output | 1 | Read request |
| memAddr | output | 64 | Read byte address |
| memWide | output | 1 | Read size, 1 for 8 bytes, 0 for 4 bytes |
| memGnt | input | 1 | Request accepted this cycle |
| memValid | input | 1 | Read data valid this cycle |
| memRdata | input | 64 | Read data |
| destOut | output | VEC_W | Merged destination |
| maskOut | output | VEC_W | Mask with completed lanes cleared |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory side follows its protocol. `memGnt` is raised only while `memReq` is high. Exactly one `memValid` pulse follows each grant, no earlier than the cycle after it. `vecLong` is set only when `VEC_W` is 256. The bench memory model keeps to these rules by construction. It grants a waiting request only when no read is outstanding, and it answers each grant after a programmed delay. The mode inputs in the stimulus cover all eight combinations.

// File: rtl/gather_pkg.sv
package gather_pkg;

  localparam int ADDR_W = 64;
  localparam int ELEM_W = 64;

  typedef struct packed {
    logic load;
    logic merge;
    logic finish;
  } gath_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } gath_state_t;

  function automatic int unsigned laneCount(input logic idxWide,
                                            input logic dataWide,
                                            input logic vecLong);
    int unsigned n;
    n = (idxWide || dataWide) ? 2 : 4;
    return vecLong ? 2 * n : n;
  endfunction

endpackage

// File: rtl/gather_ctrl.sv
module gather_ctrl
  import gather_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         anyPend,
  input  logic         moreLanes,
  input  logic         memGnt,
  input  logic         memValid,
  output gath_strobe_t strb,
  output logic         memReq,
  output logic         busy,
  output logic         done
);

  gath_state_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: if (anyPend) begin
        nextState = ST_REQ;
      end else begin
        strb.finish = 1'b1;
        nextState   = ST_FIN;
      end
      ST_REQ: if (memGnt) nextState = ST_WAIT;
      ST_WAIT: if (memValid) begin
        strb.merge = 1'b1;
        if (moreLanes) begin
          nextState = ST_REQ;
        end else begin
          strb.finish = 1'b1;
          nextState   = ST_FIN;
        end
      end
      ST_FIN: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign memReq = (state == ST_REQ);
  assign busy   = (state != ST_IDLE);
  assign done   = (state == ST_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq);

endmodule

// File: rtl/gather_dp.sv
module gather_dp
  import gather_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  gath_strobe_t        strb,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [VEC_W-1:0]    idxVec,
  input  logic [1:0]          scaleSel,
  input  logic [VEC_W-1:0]    maskIn,
  input  logic [VEC_W-1:0]    destIn,
  input  logic                idxWide,
  input  logic                dataWide,
  input  logic                vecLong,
  input  logic [ELEM_W-1:0]   memRdata,
  output logic                anyPend,
  output logic                moreLanes,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWide,
  output logic [VEC_W-1:0]    destOut,
  output logic [VEC_W-1:0]    maskOut
);

  localparam int LANES32 = VEC_W / 32;
  localparam int LANES64 = VEC_W / 64;
  localparam int LANE_W  = $clog2(LANES32);
  localparam int CNT_W   = LANE_W + 1;
  localparam int BITS_W  = $clog2(VEC_W) + 1;
  localparam logic [VEC_W:0] ONE_EXT = (VEC_W + 1)'(1);

  logic [ADDR_W-1:0] baseR;
  logic [VEC_W-1:0]  idxR, maskR, destR;
  logic [1:0]        scaleR;
  logic              idxWideR, dataWideR, vecLongR;

  function automatic logic [VEC_W-1:0] fillLow(input logic [BITS_W-1:0] nBits);
    logic [VEC_W:0] t;
    t = (ONE_EXT << nBits) - ONE_EXT;
    return t[VEC_W-1:0];
  endfunction

  function automatic logic [BITS_W-1:0] activeBits(input logic iw, input logic dw,
                                                   input logic vl);
    int unsigned n;
    n = laneCount(iw, dw, vl) * (dw ? 64 : 32);
    return BITS_W'(n);
  endfunction

  logic [VEC_W-1:0] keepIn;
  assign keepIn = fillLow(activeBits(idxWide, dataWide, vecLong));

  logic [CNT_W-1:0] laneCnt;
  assign laneCnt = CNT_W'(laneCount(idxWideR, dataWideR, vecLongR));

  // Lane enable vector from mask sign bits of data-wide lanes
  logic [LANES32-1:0] pendVec;
  for (genvar g = 0; g < LANES32; g++) begin : g_pend
    if (g < LANES64) begin : g_both
      assign pendVec[g] = (CNT_W'(g) < laneCnt) &&
                          (dataWideR ? maskR[64*g+63] : maskR[32*g+31]);
    end else begin : g_narrow
      assign pendVec[g] = (CNT_W'(g) < laneCnt) && !dataWideR && maskR[32*g+31];
    end
  end

  logic [LANE_W-1:0] curLane;
  always_comb begin
    curLane = '0;
    for (int i = LANES32 - 1; i >= 0; i--) begin
      if (pendVec[i]) curLane = LANE_W'(i);
    end
  end

  assign anyPend   = |pendVec;
  assign moreLanes = |(pendVec & ~(LANES32'(1) << curLane));

  // Index lanes and address generation
  logic [31:0] idxArr32 [LANES32];
  logic [63:0] idxArr64 [LANES64];
  for (genvar g = 0; g < LANES32; g++) begin : g_i32
    assign idxArr32[g] = idxR[32*g +: 32];
  end
  for (genvar g = 0; g < LANES64; g++) begin : g_i64
    assign idxArr64[g] = idxR[64*g +: 64];
  end

  logic [31:0]       narrowIdx;
  logic [ADDR_W-1:0] offset;
  assign narrowIdx = idxArr32[curLane];
  assign offset    = idxWideR ? idxArr64[curLane[LANE_W-2:0]]
                              : {{(ADDR_W-32){narrowIdx[31]}}, narrowIdx};
  assign memAddr   = baseR + (offset << scaleR);
  assign memWide   = dataWideR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR     <= '0;
      idxR      <= '0;
      maskR     <= '0;
      destR     <= '0;
      scaleR    <= '0;
      idxWideR  <= 1'b0;
      dataWideR <= 1'b0;
      vecLongR  <= 1'b0;
    end else if (strb.load) begin
      baseR     <= baseAddr;
      idxR      <= idxVec;
      maskR     <= maskIn;
      destR     <= destIn & keepIn;
      scaleR    <= scaleSel;
      idxWideR  <= idxWide;
      dataWideR <= dataWide;
      vecLongR  <= vecLong;
    end else begin
      if (strb.merge) begin
        if (dataWideR) begin
          for (int j = 0; j < LANES64; j++) begin
            if (curLane == LANE_W'(j)) begin
              destR[64*j +: 64] <= memRdata;
              maskR[64*j +: 64] <= '0;
            end
          end
        end else begin
          for (int i = 0; i < LANES32; i++) begin
            if (curLane == LANE_W'(i)) begin
              destR[32*i +: 32] <= memRdata[31:0];
              maskR[32*i +: 32] <= '0;
            end
          end
        end
      end
      if (strb.finish) maskR <= '0;
    end
  end

  assign destOut = destR;
  assign maskOut = maskR;

  // R7
  pend_retire_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ((pendVec & ~$past(pendVec)) == '0));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (destR & ~fillLow(activeBits(idxWideR, dataWideR, vecLongR))) == '0);

endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [ADDR_W-1:0]   baseAddr,
  input  logic [VEC_W-1:0]    idxVec,
  input  logic [1:0]          scaleSel,
  input  logic [VEC_W-1:0]    maskIn,
  input  logic [VEC_W-1:0]    destIn,
  input  logic                idxWide,
  input  logic                dataWide,
  input  logic                vecLong,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memWide,
  input  logic                memGnt,
  input  logic                memValid,
  input  logic [ELEM_W-1:0]   memRdata,
  output logic [VEC_W-1:0]    destOut,
  output logic [VEC_W-1:0]    maskOut,
  output logic                busy,
  output logic                done
);

  gath_strobe_t strb;
  logic         anyPend, moreLanes;

  gather_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .anyPend   (anyPend),
    .moreLanes (moreLanes),
    .memGnt    (memGnt),
    .memValid  (memValid),
    .strb      (strb),
    .memReq    (memReq),
    .busy      (busy),
    .done      (done)
  );

  gather_dp #(.VEC_W(VEC_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .baseAddr  (baseAddr),
    .idxVec    (idxVec),
    .scaleSel  (scaleSel),
    .maskIn    (maskIn),
    .destIn    (destIn),
    .idxWide   (idxWide),
    .dataWide  (dataWide),
    .vecLong   (vecLong),
    .memRdata  (memRdata),
    .anyPend   (anyPend),
    .moreLanes (moreLanes),
    .memAddr   (memAddr),
    .memWide   (memWide),
    .destOut   (destOut),
    .maskOut   (maskOut)
  );

  // R7
  done_mask_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (maskOut == '0));

  // R6
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> $stable(memAddr));

endmodule

// File: tb/gather_seq_tb.sv
`timescale 1ns/1ps
module gather_seq_tb;

  localparam int VEC_W = 256;

  // {mode[2]=vecLong,[1]=dataWide,[0]=idxWide, scale, laneEn, gntDly, rspDly, base16}
  localparam logic [32:0] VECS [8] = '{
    {3'b000, 2'd2, 8'b0000_1011, 2'd0, 2'd0, 16'h1000},
    {3'b001, 2'd3, 8'b1111_1111, 2'd1, 2'd2, 16'hFFFF},
    {3'b010, 2'd0, 8'b0000_0010, 2'd0, 2'd1, 16'h2000},
    {3'b011, 2'd1, 8'b0000_0011, 2'd2, 2'd0, 16'h3000},
    {3'b100, 2'd2, 8'b1010_0110, 2'd1, 2'd1, 16'h4000},
    {3'b101, 2'd3, 8'b1111_1101, 2'd0, 2'd3, 16'h5000},
    {3'b110, 2'd3, 8'b0000_1001, 2'd3, 2'd0, 16'hFFFE},
    {3'b111, 2'd0, 8'b0000_0111, 2'd0, 2'd0, 16'h7000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              start = 1'b0;
  logic [63:0]       baseAddr = '0;
  logic [VEC_W-1:0]  idxVec = '0, maskIn = '0, destIn = '0;
  logic [1:0]        scaleSel = '0;
  logic              idxWide = 1'b0, dataWide = 1'b0, vecLong = 1'b0;
  logic              memReq, memWide, memGnt, memValid, busy, done;
  logic [63:0]       memAddr, memRdata;
  logic [VEC_W-1:0]  destOut, maskOut;

  gather_seq #(.VEC_W(VEC_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .idxVec(idxVec),
    .scaleSel(scaleSel), .maskIn(maskIn), .destIn(destIn), .idxWide(idxWide),
    .dataWide(dataWide), .vecLong(vecLong), .memReq(memReq), .memAddr(memAddr),
    .memWide(memWide), .memGnt(memGnt), .memValid(memValid), .memRdata(memRdata),
    .destOut(destOut), .maskOut(maskOut), .busy(busy), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;

  function automatic logic [63:0] memData(input logic [63:0] a);
    return {~a[31:0] ^ a[63:32], a[31:0] ^ 32'h5A5A_0F0F};
  endfunction

  // memory model
  int          gntDly = 0, rspDly = 0;
  int          gntCnt = 0, rspCnt = 0;
  bit          outstanding = 0;
  logic [63:0] grantAddr = '0;
  logic [63:0] addrLog [64];
  logic        wideLog [64];
  int          reqCount = 0, overlapErr = 0, validCyc = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      memGnt      <= 1'b0;
      memValid    <= 1'b0;
      memRdata    <= '0;
      outstanding = 0;
      gntCnt      = 0;
    end else begin
      memValid <= 1'b0;
      if (memGnt) begin
        memGnt      <= 1'b0;
        outstanding = 1;
        rspCnt      = rspDly;
        reqCount    = reqCount + 1;
      end else if (outstanding) begin
        if (rspCnt == 0) begin
          memValid    <= 1'b1;
          memRdata    <= memData(grantAddr);
          outstanding = 0;
          validCyc    = cyc;
        end else begin
          rspCnt = rspCnt - 1;
        end
      end else if (memReq) begin
        if (gntCnt >= gntDly) begin
          memGnt    <= 1'b1;
          grantAddr = memAddr;
          addrLog[reqCount % 64] = memAddr;
          wideLog[reqCount % 64] = memWide;
          gntCnt    = 0;
        end else begin
          gntCnt = gntCnt + 1;
        end
      end
      if (memReq && outstanding) overlapErr = overlapErr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] mode, input logic [1:0] sc,
                       input logic [7:0] en, input int gd, input int rd,
                       input logic [15:0] b16, input int v, input int injectAt);
    logic [VEC_W-1:0] iv, mv, dv, expD, keep;
    logic [63:0]      b, idx, addr, d;
    logic [63:0]      expA [8];
    int               lanes, nExp, reqBase, ovBase, startCyc, doneCyc, waited;
    bit               iw, dw, vl, ok;
    vl = mode[2]; dw = mode[1]; iw = mode[0];
    b  = {b16, 48'h0000_0000_0100};
    for (int w = 0; w < 8; w++) begin
      iv[32*w +: 32] = (32'h9E37_79B9 * (w + 1)) ^ (32'(v) * 32'h0101_0013);
      dv[32*w +: 32] = 32'hD000_0000 + 32'(w) * 32'h0101_0101 + 32'(v);
      mv[32*w +: 32] = 32'h9357_2468 ^ 32'(w);
    end
    for (int l = 0; l < 8; l++) begin
      if (dw) begin
        if (l < 4) mv[64*l + 63] = en[l];
      end else begin
        mv[32*l + 31] = en[l];
      end
    end
    // reference model
    lanes = ((dw || iw) ? 2 : 4) * (vl ? 2 : 1);
    expD = '0; keep = '0; nExp = 0;
    for (int l = 0; l < lanes; l++) begin
      bit e;
      e = dw ? mv[64*l + 63] : mv[32*l + 31];
      if (iw) idx = iv[64*l +: 64];
      else    idx = {{32{iv[32*l + 31]}}, iv[32*l +: 32]};
      addr = b + (idx << sc);
      d    = memData(addr);
      if (dw) begin
        keep[64*l +: 64] = '1;
        expD[64*l +: 64] = e ? d : dv[64*l +: 64];
      end else begin
        keep[32*l +: 32] = '1;
        expD[32*l +: 32] = e ? d[31:0] : dv[32*l +: 32];
      end
      if (e) begin
        expA[nExp] = addr;
        nExp++;
      end
    end
    // drive
    @(negedge clk);
    gntDly = gd; rspDly = rd;
    reqBase = reqCount; ovBase = overlapErr;
    baseAddr = b; idxVec = iv; maskIn = mv; destIn = dv; scaleSel = sc;
    idxWide = iw; dataWide = dw; vecLong = vl;
    start = 1'b1; startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      if (waited == injectAt) begin
        start = 1'b1; maskIn = '1; destIn = ~dv; idxWide = ~iw; scaleSel = ~sc;
        baseAddr = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      waited++;
    end
    start = 1'b0;
    doneCyc = cyc;
    check(done == 1'b1, "R9 completion reached", 256'(done), 256'(1));
    check(destOut == expD, "R4 R5 destination merge", destOut, expD);
    check((destOut & ~keep) == '0, "R8 upper bits zero", destOut & ~keep, '0);
    check(maskOut == '0, "R7 mask cleared", maskOut, '0);
    check(reqCount - reqBase == nExp, "R1 R2 request count",
          256'(reqCount - reqBase), 256'(nExp));
    ok = 1;
    for (int k = 0; k < nExp && k < reqCount - reqBase; k++) begin
      if (addrLog[(reqBase + k) % 64] != expA[k]) ok = 0;
      if (wideLog[(reqBase + k) % 64] != dw) ok = 0;
    end
    check(ok, "R3 R5 R6 address order and size", 256'(ok), 256'(1));
    check(overlapErr == ovBase, "R6 single outstanding",
          256'(overlapErr - ovBase), 256'(0));
    if (nExp > 0)
      check(doneCyc == validCyc + 1, "R9 done timing",
            256'(doneCyc), 256'(validCyc + 1));
    else
      check(doneCyc == startCyc + 2, "R9 empty mask done timing",
            256'(doneCyc), 256'(startCyc + 2));
    @(negedge clk);
    check(!done && !busy, "R9 R10 single pulse and idle after",
          256'({done, busy}), 256'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check(destOut == '0, "R11 reset destOut", destOut, '0);
    check(maskOut == '0, "R11 reset maskOut", maskOut, '0);
    check({busy, memReq, done} == 3'b000, "R11 reset controls",
          256'({busy, memReq, done}), 256'(0));
    rstN = 1'b1;
    @(negedge clk);
    check({busy, memReq, done} == 3'b000, "R11 idle after reset",
          256'({busy, memReq, done}), 256'(0));

    // table of all mode combinations
    for (int v = 0; v < 8; v++) begin
      logic [32:0] e;
      e = VECS[v];
      runOp(e[32:30], e[29:28], e[27:20], int'(e[19:18]), int'(e[17:16]),
            e[15:0], v, -1);
    end

    // R9 all-clear mask: no request, early done
    runOp(3'b100, 2'd1, 8'h00, 0, 0, 16'h8000, 9, -1);
    runOp(3'b011, 2'd2, 8'h00, 0, 0, 16'h8100, 10, -1);
    // R1 lanes beyond the count in narrow mode ignored even if signed
    runOp(3'b001, 2'd0, 8'b1111_1100, 0, 0, 16'h8200, 11, -1);
    // R10 start during busy ignored
    runOp(3'b100, 2'd2, 8'b1100_0011, 3, 3, 16'h9000, 12, 1);
    runOp(3'b111, 2'd3, 8'b0000_1010, 2, 2, 16'h9100, 13, 4);
    // back-to-back grants with no delay
    runOp(3'b100, 2'd0, 8'hFF, 0, 0, 16'hA000, 14, -1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule